// File: doc/BRIEF.md
# Compare Timer Channel

This block is one 32-bit timer channel behind a small byte-addressed synchronous register port. Software loads a compare value, picks a mode, and then uses separate write-only strobe registers to start or stop the count. A read-only status register shows whether the channel is running. The counter advances only in cycles where the `tick_en` input is high. Each timer event produces a one-cycle pulse on `irq_pulse`.

There are two modes. Interval mode treats the compare value as the period minus one. It counts down from the compare value and reloads it, with a pulse, on the tick that finds the count at zero. Free-running mode clears the counter on start and counts upward, wrapping modulo 2^CNT_W, so the counter can serve as a time base. It pulses on the tick that brings the count equal to the compare value. The mode is captured when the channel starts. Compare and mode are meant to be set while the channel is stopped.

The control state machine has three states:
- `ST_STOPPED`: idle; the counter holds its value.
- `ST_INTERVAL`: the down-counting interval mode.
- `ST_FREERUN`: the up-counting compare mode.

Its transitions are:
- START: from any state into the run state that the mode bit selects, loading the counter.
- STOP: from any state into `ST_STOPPED`.
- RELOAD: the interval tick at zero, which stays in `ST_INTERVAL`.
- STEP: an ordinary tick, which stays in the current run state.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the channel is stopped and `irq_pulse` is 0. The compare, counter, status and control registers all read 0.
- R2: The register port has these byte addresses: compare 0x00, counter 0x04, status 0x10, start 0x14, stop 0x18 and control 0x20.
  - Compare reads back the value written to it.
  - Control keeps only bit 1 (the mode bit), and every other control bit reads 0.
  - The start address, the stop address and unmapped addresses read 0.
- R3: Writes to the counter address (0x04) and the status address (0x10) are ignored.
- R4: A write to the start address with data bit 0 set starts the channel, and status bit 0 reads 1 from the next cycle. A start write with bit 0 clear has no effect.
- R5: A write to the stop address with data bit 0 set halts the channel. After it, status bit 0 reads 0, the counter holds its value, and no pulse occurs. A stop while already stopped changes nothing.
- R6: In interval mode (control bit 1 = 0):
  - Start loads the counter with the compare value C.
  - Each tick decrements the counter.
  - The tick that finds the counter at 0 reloads C and pulses, so pulses come every C+1 ticks.
- R7: In free-running mode (control bit 1 = 1), start clears the counter to 0. Each tick then adds one, wrapping from all-ones to 0.
- R8: In free-running mode a pulse occurs on the tick that makes the counter equal to the compare value, for example 0xF ticks after start when the compare value is 0xF.
- R9: `irq_pulse` is high for one cycle per event and only while running. Cycles with `tick_en` low do not advance the counter.
- R10: A start strobe while running restarts the count from the mode's initial value.
- R11: A start or stop strobe in the same cycle as a tick takes priority: the tick is dropped and no pulse is produced in that cycle.
- R12: The mode is captured at start. Changing control while running does not alter behaviour until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the address |
| irq_pulse | output | 1 | One-cycle event pulse |

## Verification
A strobe write and a counting tick can fall in the same clock. The sharpest case is the interval tick that finds the counter at zero, which would otherwise reload the counter and pulse. The bench provokes this by running the count down to zero and then holding `tick_en` high during the cycle of a start or a stop write. It judges the outcome from the event scoreboard, which must see no pulse. After the start write the counter must read the reloaded compare value. After the stop write the counter must still read 0 and the status must read 0.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_INTERVAL = 2'd1,
        ST_FREERUN  = 2'd2
    } run_state_t;

    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_LOAD_CMP = 3'd1,
        OP_CLEAR    = 3'd2,
        OP_DOWN     = 3'd3,
        OP_UP       = 3'd4
    } cnt_op_t;

    localparam int unsigned OFF_COMPARE = 'h00;
    localparam int unsigned OFF_COUNT   = 'h04;
    localparam int unsigned OFF_STATUS  = 'h10;
    localparam int unsigned OFF_START   = 'h14;
    localparam int unsigned OFF_STOP    = 'h18;
    localparam int unsigned OFF_CONTROL = 'h20;

    localparam int unsigned STROBE_BIT = 0;
    localparam int unsigned MODE_BIT   = 1;

endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              running,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              mode_free,
    output logic              start_stb,
    output logic              stop_stb,
    output logic [DATA_W-1:0] bus_rdata
);

    logic wr_en;
    logic hit_cmp, hit_cnt, hit_sts, hit_ctl, hit_start, hit_stop;

    assign wr_en     = bus_sel & bus_we;
    assign hit_cmp   = (bus_addr == ADDR_W'(OFF_COMPARE));
    assign hit_cnt   = (bus_addr == ADDR_W'(OFF_COUNT));
    assign hit_sts   = (bus_addr == ADDR_W'(OFF_STATUS));
    assign hit_start = (bus_addr == ADDR_W'(OFF_START));
    assign hit_stop  = (bus_addr == ADDR_W'(OFF_STOP));
    assign hit_ctl   = (bus_addr == ADDR_W'(OFF_CONTROL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val   <= '0;
            mode_free <= 1'b0;
        end else if (wr_en) begin
            if (hit_cmp) cmp_val   <= bus_wdata[CNT_W-1:0];
            if (hit_ctl) mode_free <= bus_wdata[MODE_BIT];
        end
    end

    assign start_stb = wr_en & hit_start & bus_wdata[STROBE_BIT];
    assign stop_stb  = wr_en & hit_stop  & bus_wdata[STROBE_BIT];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (hit_cmp)      bus_rdata = DATA_W'(cmp_val);
            else if (hit_cnt) bus_rdata = DATA_W'(count);
            else if (hit_sts) bus_rdata = DATA_W'(running);
            else if (hit_ctl) bus_rdata = DATA_W'({mode_free, 1'b0});
        end
    end

endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_t          op,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             at_zero,
    output logic             up_hits_cmp
);

    logic [CNT_W-1:0] count_up;

    assign count_up    = count + 1'b1;
    assign at_zero     = (count == '0);
    assign up_hits_cmp = (count_up == cmp_val);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                OP_HOLD:     count <= count;
                OP_LOAD_CMP: count <= cmp_val;
                OP_CLEAR:    count <= '0;
                OP_DOWN:     count <= count - 1'b1;
                OP_UP:       count <= count_up;
                default:     count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cmp_timer_fsm.sv
module cmp_timer_fsm
    import cmp_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_stb,
    input  logic       stop_stb,
    input  logic       mode_free,
    input  logic       tick_en,
    input  logic       at_zero,
    input  logic       up_hits_cmp,
    output run_state_t state,
    output cnt_op_t    op,
    output logic       irq_pulse
);

    run_state_t state_nx;
    logic       irq_nx;

    always_comb begin
        state_nx = state;
        op       = OP_HOLD;
        irq_nx   = 1'b0;
        if (start_stb) begin
            state_nx = mode_free ? ST_FREERUN : ST_INTERVAL;
            op       = mode_free ? OP_CLEAR : OP_LOAD_CMP;
        end else if (stop_stb) begin
            state_nx = ST_STOPPED;
        end else begin
            unique case (state)
                ST_STOPPED: ;
                ST_INTERVAL: begin
                    if (tick_en) begin
                        if (at_zero) begin
                            op     = OP_LOAD_CMP;
                            irq_nx = 1'b1;
                        end else begin
                            op = OP_DOWN;
                        end
                    end
                end
                ST_FREERUN: begin
                    if (tick_en) begin
                        op     = OP_UP;
                        irq_nx = up_hits_cmp;
                    end
                end
                default: state_nx = ST_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOPPED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= irq_nx;
    end

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import cmp_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_pulse
);

    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] count;
    logic             mode_free, start_stb, stop_stb;
    logic             at_zero, up_hits_cmp, running;
    run_state_t       state;
    cnt_op_t          op;

    assign running = (state != ST_STOPPED);

    cmp_timer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count),
        .running(running), .cmp_val(cmp_val), .mode_free(mode_free),
        .start_stb(start_stb), .stop_stb(stop_stb), .bus_rdata(bus_rdata)
    );

    cmp_timer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_stb(start_stb), .stop_stb(stop_stb),
        .mode_free(mode_free), .tick_en(tick_en), .at_zero(at_zero),
        .up_hits_cmp(up_hits_cmp), .state(state), .op(op), .irq_pulse(irq_pulse)
    );

    cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .op(op), .cmp_val(cmp_val),
        .count(count), .at_zero(at_zero), .up_hits_cmp(up_hits_cmp)
    );

    // R4: a start strobe always leaves the channel running
    a_r4_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> running);

    // R5: a stop strobe always leaves the channel stopped
    a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |=> !running);

    // R5: a stopped channel keeps its count until a start
    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start_stb) |=> $stable(count));

    // R9: without a tick or start the count does not move
    a_r9_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !start_stb) |=> $stable(count));

    // R9: pulses only come out of a running channel
    a_r9_irq_running: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(running));

    // R6: interval tick at zero reloads compare and pulses
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTERVAL && tick_en && count == '0 && !start_stb && !stop_stb)
        |=> (count == $past(cmp_val) && irq_pulse));

    // R7: free-running tick adds one modulo the counter width
    a_r7_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREERUN && tick_en && !start_stb && !stop_stb)
        |=> count == CNT_W'($past(count) + 1'b1));

    // R11: strobe in a tick cycle suppresses the pulse
    a_r11_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stb || stop_stb) |=> !irq_pulse);

endmodule

// File: tb/cmp_timer_chan_bench.sv
module cmp_timer_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        sel = 1'b0, nsel = 1'b0, we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_n;
    logic        irq, irq_n;

    int unsigned cyc = 0;
    int          n_cmp = 0, n_bad = 0, n_irq_narrow = 0;
    int unsigned exp_q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    cmp_timer_chan u_cmp_timer_chan (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_pulse(irq)
    );

    cmp_timer_chan #(.CNT_W(8)) u_cmp_timer_chan_narrow (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(nsel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_n), .irq_pulse(irq_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: each pulse must match the next expected cycle
    always @(negedge clk) begin
        if (rst_n && irq) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R9 pulse: actual cycle %0d expected none", cyc);
            end else if (exp_q[0] != cyc) begin
                n_bad++;
                $display("FAIL R6/R8 pulse: actual cycle %0d expected %0d", cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end else begin
                void'(exp_q.pop_front());
            end
        end
        if (rst_n && irq_n) n_irq_narrow++;
    end

    task automatic wr(input logic narrow, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = !narrow; nsel = narrow; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; nsel = 1'b0; we = 1'b0;
    endtask

    task automatic wr_tick(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d; tick_en = 1'b1;
        @(negedge clk);
        sel = 1'b0; we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic narrow, input logic [5:0] a,
                          input logic [31:0] exp);
        logic [31:0] v;
        @(negedge clk);
        sel = !narrow; nsel = narrow; we = 1'b0; addr = a;
        #1;
        v = narrow ? rdata_n : rdata;
        sel = 1'b0; nsel = 1'b0;
        check(tag, v, exp);
    endtask

    // driver: push expected pulse cycles, then apply n ticks
    task automatic run_ticks(input int n, input int first, input int period);
        int unsigned c0;
        @(negedge clk);
        c0 = cyc;
        if (first > 0)
            for (int k = first; k <= n; k += (period == 0) ? n + 1 : period)
                exp_q.push_back(c0 + k);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_chk("R1 compare", 0, 6'h00, 32'h0);
        rd_chk("R1 counter", 0, 6'h04, 32'h0);
        rd_chk("R1 status",  0, 6'h10, 32'h0);
        rd_chk("R1 control", 0, 6'h20, 32'h0);
        // R2 register map
        wr(0, 6'h00, 32'hA5A5_1234);
        rd_chk("R2 compare rw", 0, 6'h00, 32'hA5A5_1234);
        wr(0, 6'h20, 32'hFF);
        rd_chk("R2 control bit1 only", 0, 6'h20, 32'h2);
        rd_chk("R2 start reads 0", 0, 6'h14, 32'h0);
        rd_chk("R2 stop reads 0",  0, 6'h18, 32'h0);
        rd_chk("R2 unmapped reads 0", 0, 6'h08, 32'h0);
        wr(0, 6'h20, 32'h0);
        // R4 start with bit0 clear
        wr(0, 6'h14, 32'hFE);
        rd_chk("R4 start bit0 clear ignored", 0, 6'h10, 32'h0);
        // R6 interval mode, period 5; R12 mode change while running
        wr(0, 6'h00, 32'd4);
        wr(0, 6'h14, 32'h1);
        rd_chk("R4 status after start", 0, 6'h10, 32'h1);
        rd_chk("R6 counter loaded", 0, 6'h04, 32'd4);
        wr(0, 6'h20, 32'h2);
        run_ticks(12, 5, 5);
        rd_chk("R6 R12 counter after 12 ticks", 0, 6'h04, 32'd2);
        // R3 read-only registers ignore writes
        wr(0, 6'h04, 32'h1234);
        rd_chk("R3 counter write ignored", 0, 6'h04, 32'd2);
        wr(0, 6'h10, 32'h0);
        rd_chk("R3 status write ignored", 0, 6'h10, 32'h1);
        // R5 stop
        wr(0, 6'h18, 32'h1);
        rd_chk("R5 status after stop", 0, 6'h10, 32'h0);
        run_ticks(5, 0, 0);
        rd_chk("R5 counter held", 0, 6'h04, 32'd2);
        wr(0, 6'h18, 32'h1);
        rd_chk("R5 stop while stopped status", 0, 6'h10, 32'h0);
        rd_chk("R5 stop while stopped counter", 0, 6'h04, 32'd2);
        // R7 R8 free-running, minimum delta 0xF
        wr(0, 6'h00, 32'hF);
        wr(0, 6'h14, 32'h1);
        rd_chk("R7 counter cleared on start", 0, 6'h04, 32'd0);
        run_ticks(20, 15, 0);
        rd_chk("R7 R8 counter after 20 ticks", 0, 6'h04, 32'd20);
        repeat (3) @(negedge clk);
        rd_chk("R9 no tick no advance", 0, 6'h04, 32'd20);
        // R10 restart while running
        wr(0, 6'h14, 32'h1);
        rd_chk("R10 restart clears", 0, 6'h04, 32'd0);
        run_ticks(16, 15, 0);
        rd_chk("R10 counter after restart", 0, 6'h04, 32'd16);
        // R11 strobes on the zero tick
        wr(0, 6'h20, 32'h0);
        wr(0, 6'h00, 32'd3);
        wr(0, 6'h14, 32'h1);
        run_ticks(3, 0, 0);
        rd_chk("R6 counter at zero", 0, 6'h04, 32'd0);
        wr_tick(6'h14, 32'h1);
        rd_chk("R11 start beats zero tick", 0, 6'h04, 32'd3);
        run_ticks(3, 0, 0);
        wr_tick(6'h18, 32'h1);
        rd_chk("R11 stop beats zero tick status", 0, 6'h10, 32'h0);
        rd_chk("R11 stop beats zero tick counter", 0, 6'h04, 32'd0);
        // R7 wrap on the 8-bit channel
        wr(1, 6'h20, 32'h2);
        wr(1, 6'h00, 32'd5);
        wr(1, 6'h14, 32'h1);
        run_ticks(260, 0, 0);
        rd_chk("R7 narrow wrap", 1, 6'h04, 32'd4);
        check("R8 narrow pulse count", 32'(n_irq_narrow), 32'd1);
        repeat (2) @(negedge clk);
        while (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R6/R8 missed pulse: actual none expected cycle %0d", exp_q[0]);
            void'(exp_q.pop_front());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule